// File: doc/BRIEF.md
# Pipelined Carry-Select Adder with Condition Flags

This block adds or subtracts two 32-bit operands for an FPGA datapath. It breaks the word into 8-bit ripple-carry segments. The least significant segment is evaluated once, using the real carry-in. Each higher segment is evaluated twice in parallel: once on the assumption that its carry-in is 0 and once on the assumption that it is 1. No carry has to ripple across the whole word within one cycle.

The first register stage holds every segment result. The second stage walks the segment carries, picks the correct half of each upper pair and puts the word back together. The third stage computes the negative, zero, carry and overflow flags from the selected word and registers them with the sum.

A valid bit travels with each operation, so the block can accept a new operation on every clock. The result always appears a fixed three cycles later.

Top module: `pipe_csa_adder`

## Requirements
- R1: With `in_sub` = 0, `out_sum` equals `in_a + in_b + in_cin` modulo 2^32.
- R2: With `in_sub` = 1, `out_sum` equals `in_a - in_b` modulo 2^32. The operand is inverted and the carry-in is forced to 1, so `in_cin` has no effect on any output.
- R3: An operation sampled on rising edge n, with `in_valid` = 1, shows its result and `out_valid` = 1 on the outputs just after rising edge n+2.
- R4: `out_valid` is 1 only for cycles that carry an accepted operation. Operations may be presented on consecutive cycles. Each one yields exactly one result, in issue order.
- R5: `out_c` is the carry out of bit 31. For a subtraction, 1 means no borrow.
- R6: `out_v` is the XOR of the carry into bit 31 and the carry out of bit 31 (signed overflow).
- R7: `out_z` is 1 exactly when all 32 bits of `out_sum` are 0.
- R8: `out_n` equals bit 31 of `out_sum`.
- R9: A carry generated in the lowest segment propagates correctly through every upper segment boundary, for example 0xFFFFFFFF + 1 gives 0 with `out_c` = 1.
- R10: While `rst_n` is low, `out_valid`, `out_sum` and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand (subtrahend when subtracting) |
| in_cin | input | 1 | Carry-in for addition |
| in_sub | input | 1 | 1 selects subtraction |
| out_valid | output | 1 | Result present this cycle |
| out_sum | output | 32 | Result word |
| out_n | output | 1 | Negative flag |
| out_z | output | 1 | Zero flag |
| out_c | output | 1 | Carry flag |
| out_v | output | 1 | Overflow flag |

## Verification
The end-to-end assertions compare an output with operands captured three cycles earlier. They therefore assume that the inputs are stable around each sampling edge and that `in_valid` is low throughout reset. The stimulus satisfies both assumptions: it changes inputs only on falling edges and holds `in_valid` at 0 until reset is released. The flag assertions assume nothing about the inputs. The stimulus mixes back-to-back operations, idle gaps, subtraction with both carry-in values, and operands chosen to send a carry across every segment boundary or to produce signed overflow.

// File: rtl/csa_pkg.sv
`timescale 1ns/1ps
package csa_pkg;

    // Number of carry assumptions evaluated for each upper segment.
    localparam int unsigned CSA_ALTS = 2;

    // One-bit full adder: returns {carry_out, sum}.
    function automatic logic [1:0] csa_fa(input logic x, input logic y, input logic ci);
        logic s;
        logic co;
        s  = x ^ y ^ ci;
        co = (x & y) | (x & ci) | (y & ci);
        return {co, s};
    endfunction

endpackage

// File: rtl/csa_ripple_seg.sv
`timescale 1ns/1ps
module csa_ripple_seg #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] seg_a,
    input  logic [W-1:0] seg_b,
    input  logic         seg_ci,
    output logic [W-1:0] seg_sum,
    output logic         seg_co
);
    import csa_pkg::*;

    // Plain ripple chain; the FPGA maps this onto its dedicated carry logic.
    always_comb begin
        logic       carry;
        logic [1:0] fa;
        carry   = seg_ci;
        seg_sum = '0;
        for (int i = 0; i < int'(W); i++) begin
            fa         = csa_fa(seg_a[i], seg_b[i], carry);
            seg_sum[i] = fa[0];
            carry      = fa[1];
        end
        seg_co = carry;
    end

endmodule

// File: rtl/csa_select_stage.sv
`timescale 1ns/1ps
module csa_select_stage #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned SEG_W = 8,
    localparam int unsigned NSEG = WIDTH / SEG_W,
    localparam int unsigned NHI  = NSEG - 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                i_valid,
    input  logic [SEG_W-1:0]                    i_lo_sum,
    input  logic                                i_lo_co,
    input  logic [NHI-1:0][1:0][SEG_W-1:0]      i_hi_sum,
    input  logic [NHI-1:0][1:0]                 i_hi_co,
    input  logic                                i_a_msb,
    input  logic                                i_b_msb,
    output logic                                o_valid,
    output logic [WIDTH-1:0]                    o_sum,
    output logic                                o_co,
    output logic                                o_a_msb,
    output logic                                o_b_msb
);

    typedef struct packed {
        logic             valid;
        logic [WIDTH-1:0] sum;
        logic             co;
        logic             a_msb;
        logic             b_msb;
    } sel_t;

    sel_t sel_d, sel_q;

    // Resolve the carry into each upper segment and keep the matching result.
    always_comb begin
        logic carry;
        sel_d       = '0;
        sel_d.valid = i_valid;
        sel_d.a_msb = i_a_msb;
        sel_d.b_msb = i_b_msb;
        sel_d.sum[SEG_W-1:0] = i_lo_sum;
        carry = i_lo_co;
        for (int h = 0; h < int'(NHI); h++) begin
            sel_d.sum[(h+1)*SEG_W +: SEG_W] = i_hi_sum[h][carry];
            carry = i_hi_co[h][carry];
        end
        sel_d.co = carry;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else begin
            sel_q <= sel_d;
        end
    end

    assign o_valid = sel_q.valid;
    assign o_sum   = sel_q.sum;
    assign o_co    = sel_q.co;
    assign o_a_msb = sel_q.a_msb;
    assign o_b_msb = sel_q.b_msb;

    AST_SEL_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid == $past(i_valid)) else $error("select stage lost or invented an item"); // R4

endmodule

// File: rtl/csa_flag_stage.sv
`timescale 1ns/1ps
module csa_flag_stage #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             i_valid,
    input  logic [WIDTH-1:0] i_sum,
    input  logic             i_co,
    input  logic             i_a_msb,
    input  logic             i_b_msb,
    output logic             o_valid,
    output logic [WIDTH-1:0] o_sum,
    output logic             o_n,
    output logic             o_z,
    output logic             o_c,
    output logic             o_v
);
    import csa_pkg::*;

    typedef struct packed {
        logic             valid;
        logic [WIDTH-1:0] sum;
        logic             n;
        logic             z;
        logic             c;
        logic             v;
    } res_t;

    res_t res_d, res_q;

    always_comb begin
        logic c_into_msb;
        // The sum bit at the MSB is a ^ b ^ carry-in, so the carry-in can be recovered.
        c_into_msb  = i_a_msb ^ i_b_msb ^ i_sum[WIDTH-1];
        res_d       = '0;
        res_d.valid = i_valid;
        res_d.sum   = i_sum;
        res_d.n     = i_sum[WIDTH-1];
        res_d.z     = ~|i_sum;
        res_d.c     = i_co;
        res_d.v     = c_into_msb ^ i_co;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign o_valid = res_q.valid;
    assign o_sum   = res_q.sum;
    assign o_n     = res_q.n;
    assign o_z     = res_q.z;
    assign o_c     = res_q.c;
    assign o_v     = res_q.v;

    AST_NEG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid |-> (o_n == o_sum[WIDTH-1])) else $error("negative flag disagrees with sum"); // R8
    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid |-> (o_z == (o_sum == '0))) else $error("zero flag disagrees with sum"); // R7
    AST_FLAG_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid == $past(i_valid)) else $error("flag stage lost or invented an item"); // R4

endmodule

// File: rtl/pipe_csa_adder.sv
`timescale 1ns/1ps
module pipe_csa_adder #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned SEG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    input  logic             in_cin,
    input  logic             in_sub,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_sum,
    output logic             out_n,
    output logic             out_z,
    output logic             out_c,
    output logic             out_v
);
    import csa_pkg::*;

    localparam int unsigned NSEG = WIDTH / SEG_W;
    localparam int unsigned NHI  = NSEG - 1;

    typedef struct packed {
        logic                                valid;
        logic [SEG_W-1:0]                    lo_sum;
        logic                                lo_co;
        logic [NHI-1:0][CSA_ALTS-1:0][SEG_W-1:0] hi_sum;
        logic [NHI-1:0][CSA_ALTS-1:0]        hi_co;
        logic                                a_msb;
        logic                                b_msb;
    } seg_t;

    seg_t s1_d, s1_q;

    logic [WIDTH-1:0] b_eff;
    logic             c_first;
    logic [SEG_W-1:0] lo_sum_w;
    logic             lo_co_w;
    logic [NHI-1:0][CSA_ALTS-1:0][SEG_W-1:0] hi_sum_w;
    logic [NHI-1:0][CSA_ALTS-1:0]            hi_co_w;

    // Subtraction is a + ~b + 1; the external carry-in is overridden.
    always_comb begin
        b_eff   = in_sub ? ~in_b : in_b;
        c_first = in_sub | in_cin;
    end

    csa_ripple_seg #(.W(SEG_W)) u_seg_lo (
        .seg_a   (in_a[SEG_W-1:0]),
        .seg_b   (b_eff[SEG_W-1:0]),
        .seg_ci  (c_first),
        .seg_sum (lo_sum_w),
        .seg_co  (lo_co_w)
    );

    for (genvar h = 0; h < int'(NHI); h++) begin : g_hi
        for (genvar k = 0; k < int'(CSA_ALTS); k++) begin : g_alt
            csa_ripple_seg #(.W(SEG_W)) u_seg (
                .seg_a   (in_a[(h+1)*SEG_W +: SEG_W]),
                .seg_b   (b_eff[(h+1)*SEG_W +: SEG_W]),
                .seg_ci  ((k == 1) ? 1'b1 : 1'b0),
                .seg_sum (hi_sum_w[h][k]),
                .seg_co  (hi_co_w[h][k])
            );
        end
    end

    always_comb begin
        s1_d        = '0;
        s1_d.valid  = in_valid;
        s1_d.lo_sum = lo_sum_w;
        s1_d.lo_co  = lo_co_w;
        s1_d.hi_sum = hi_sum_w;
        s1_d.hi_co  = hi_co_w;
        s1_d.a_msb  = in_a[WIDTH-1];
        s1_d.b_msb  = b_eff[WIDTH-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
        end else begin
            s1_q <= s1_d;
        end
    end

    logic             s2_valid;
    logic [WIDTH-1:0] s2_sum;
    logic             s2_co;
    logic             s2_a_msb;
    logic             s2_b_msb;

    csa_select_stage #(.WIDTH(WIDTH), .SEG_W(SEG_W)) u_select (
        .clk      (clk),
        .rst_n    (rst_n),
        .i_valid  (s1_q.valid),
        .i_lo_sum (s1_q.lo_sum),
        .i_lo_co  (s1_q.lo_co),
        .i_hi_sum (s1_q.hi_sum),
        .i_hi_co  (s1_q.hi_co),
        .i_a_msb  (s1_q.a_msb),
        .i_b_msb  (s1_q.b_msb),
        .o_valid  (s2_valid),
        .o_sum    (s2_sum),
        .o_co     (s2_co),
        .o_a_msb  (s2_a_msb),
        .o_b_msb  (s2_b_msb)
    );

    csa_flag_stage #(.WIDTH(WIDTH)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .i_valid (s2_valid),
        .i_sum   (s2_sum),
        .i_co    (s2_co),
        .i_a_msb (s2_a_msb),
        .i_b_msb (s2_b_msb),
        .o_valid (out_valid),
        .o_sum   (out_sum),
        .o_n     (out_n),
        .o_z     (out_z),
        .o_c     (out_c),
        .o_v     (out_v)
    );

    // End-to-end checks against a plain wide addition of the operands seen three edges back.
    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 3)) else $error("result without a matching operation"); // R3
    AST_ADD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(in_sub, 3)) |->
        ({out_c, out_sum} == ({1'b0, $past(in_a, 3)} + {1'b0, $past(in_b, 3)} + (WIDTH+1)'($past(in_cin, 3)))))
        else $error("addition result wrong"); // R1
    AST_SUB_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_sub, 3)) |->
        ({out_c, out_sum} == ({1'b0, $past(in_a, 3)} + {1'b0, ~$past(in_b, 3)} + (WIDTH+1)'(1))))
        else $error("subtraction result wrong"); // R2
    AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_v == (($past(in_a[WIDTH-1], 3) == $past(b_eff[WIDTH-1], 3)) &&
                                 (out_sum[WIDTH-1] != $past(in_a[WIDTH-1], 3)))))
        else $error("overflow flag wrong"); // R6

endmodule

// File: tb/pipe_csa_adder_test.sv
`timescale 1ns/1ps
module pipe_csa_adder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        in_cin = 1'b0;
    logic        in_sub = 1'b0;
    logic        out_valid;
    logic [31:0] out_sum;
    logic        out_n, out_z, out_c, out_v;

    always #2.5 clk = ~clk;

    pipe_csa_adder uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .in_cin(in_cin), .in_sub(in_sub), .out_valid(out_valid), .out_sum(out_sum),
        .out_n(out_n), .out_z(out_z), .out_c(out_c), .out_v(out_v)
    );

    typedef struct {
        int          due;
        logic [31:0] sum;
        logic        n, z, c, v;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Driver: presents one operation and queues the values the requirements predict.
    task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic cin,
                         input logic sub, input string tag);
        logic [31:0] bx;
        logic        ci;
        logic [32:0] full;
        exp_t        e;
        @(negedge clk);
        in_a = a; in_b = b; in_cin = cin; in_sub = sub; in_valid = 1'b1;
        bx   = sub ? ~b : b;
        ci   = sub ? 1'b1 : cin;
        full = {1'b0, a} + {1'b0, bx} + {32'd0, ci};
        e.due = cyc + 3;
        e.sum = full[31:0];
        e.c   = full[32];
        e.n   = full[31];
        e.z   = (full[31:0] == 32'd0);
        e.v   = (a[31] == bx[31]) && (full[31] != a[31]);
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_a = $urandom; in_b = $urandom; in_cin = 1'b1; in_sub = 1'b0;
        end
    endtask

    // Monitor: compares each produced result against the queue head.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                if (q.size() == 0 || q[0].due != cyc) begin
                    check(1'b0, "R4", "unexpected out_valid at cycle", 32'(cyc),
                          (q.size() == 0) ? 32'hFFFF_FFFF : 32'(q[0].due));
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(1'b1, "R3", "latency", 32'(cyc), 32'(e.due));
                    check(out_sum == e.sum, e.tag, "sum", out_sum, e.sum);
                    check(out_c == e.c, "R5", "carry flag", 32'(out_c), 32'(e.c));
                    check(out_v == e.v, "R6", "overflow flag", 32'(out_v), 32'(e.v));
                    check(out_z == e.z, "R7", "zero flag", 32'(out_z), 32'(e.z));
                    check(out_n == e.n, "R8", "negative flag", 32'(out_n), 32'(e.n));
                end
            end else if (q.size() != 0 && q[0].due == cyc) begin
                check(1'b0, "R3", "result missing at due cycle", 32'(cyc), 32'(q[0].due));
                void'(q.pop_front());
            end
        end
    end

    // Watchdog
    initial begin
        wait (cyc >= 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
            finish_run();
        end
    end

    initial begin
        // R10: outputs held at zero during reset, even with activity on the inputs
        in_a = 32'hFFFF_FFFF; in_b = 32'h1; in_cin = 1'b1;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R10", "out_valid in reset", 32'(out_valid), 32'd0);
        check(out_sum == 32'd0, "R10", "out_sum in reset", out_sum, 32'd0);
        check({out_n, out_z, out_c, out_v} == 4'd0, "R10", "flags in reset",
              32'({out_n, out_z, out_c, out_v}), 32'd0);
        rst_n = 1'b1;
        idle(2);

        // Directed cases
        drive(32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0, "R1");   // zero result
        drive(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1'b0, "R9");   // carry through every segment
        drive(32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 1'b0, "R9");   // carry-in ripples all the way
        drive(32'h00FF_FFFF, 32'h0000_0000, 1'b1, 1'b0, "R9");   // stops in the top byte
        drive(32'h0000_FF00, 32'h0000_0100, 1'b0, 1'b0, "R9");   // generated mid-word
        drive(32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 1'b0, "R1");   // positive overflow
        drive(32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0, "R1");   // negative overflow, carry, zero
        drive(32'h1234_5678, 32'h0FED_CBA9, 1'b1, 1'b0, "R1");
        idle(3);
        drive(32'h0000_0005, 32'h0000_0005, 1'b0, 1'b1, "R2");   // equal, no borrow
        drive(32'h0000_0005, 32'h0000_0005, 1'b1, 1'b1, "R2");   // carry-in ignored
        drive(32'h0000_0000, 32'h0000_0001, 1'b0, 1'b1, "R2");   // borrow
        drive(32'h0000_0000, 32'h0000_0001, 1'b1, 1'b1, "R2");   // borrow, carry-in ignored
        drive(32'h8000_0000, 32'h0000_0001, 1'b1, 1'b1, "R2");   // signed overflow
        drive(32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1, "R2");   // signed overflow other way
        idle(5);

        // Mixed traffic: back-to-back bursts with occasional gaps
        for (int i = 0; i < 300; i++) begin
            logic sub;
            sub = $urandom_range(0, 1);
            drive($urandom, $urandom, 1'($urandom_range(0, 1)), sub, sub ? "R2" : "R1");
            if ($urandom_range(0, 7) == 0) idle($urandom_range(1, 4));
        end
        idle(1);

        while (q.size() != 0) @(negedge clk);
        idle(4);
        finish_run();
    end

endmodule